// File: doc/BRIEF.md
# Correlation Key-Byte Ranker

This block ranks all 256 candidate values of one secret key byte by how well a leakage model explains a set of measured power samples. For every absorbed trace it takes the known plaintext byte and a single measured sample taken at the point of interest. For each guess k it models the leakage as the Hamming weight of the AES S-box output for the plaintext XOR k. It keeps exact integer running sums over all traces. From these sums it can later form a Pearson correlation between the modelled column and the measured column for every guess.

Software or a sequencer first clears the engine and then feeds traces one at a time. While a trace is being folded into the per-guess sums, the engine is busy for 256 cycles, one guess per cycle. Once at least two traces are in, a scan request walks all 256 guesses in 256 cycles. It returns the guess whose correlation has the largest magnitude. A strongly negative correlation counts exactly like a strongly positive one. Square roots are never formed: candidates are compared through cross-multiplied squared scores.

Top module: `cpa_rank_engine`

## Requirements
- R1: After reset, busy, result_valid, trace_count and best_key are all zero.
- R2: A trace offered with in_valid while busy is low and trace_count is below its maximum is absorbed on that clock edge. trace_count rises by one, and busy is then high for exactly 256 cycles. When in_valid and start arrive together, the trace takes precedence.
- R3: in_valid and start presented while busy is high are ignored. They change neither trace_count nor the final result.
- R4: The model value for guess k and a trace with unsigned plaintext byte p is the number of ones in S(p XOR k), where S is the standard AES forward substitution (S(0x00)=0x63, S(0x53)=0xED). in_sample is an unsigned integer.
- R5: At the end of a scan, best_key is the guess maximising the squared Pearson correlation between model and samples over all absorbed traces. A negatively correlated guess can win.
- R6: A guess replaces the current best only if its score is strictly larger, so ties go to the lowest guess. A guess whose model variance is zero scores zero and never wins. If no guess scores above zero, best_key is 0.
- R7: start is ignored while fewer than two traces have been absorbed. busy and result_valid stay low.
- R8: An accepted start makes busy high for exactly 256 cycles. result_valid is then high, and best_key is held until the next accepted trace, accepted start or clear.
- R9: clear, at any time, aborts any work and returns trace_count, result_valid and busy to zero. The next trace starts fresh sums.
- R10: trace_count saturates at 2^CW-1. Further traces are ignored and leave busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Discard all sums and abort any activity |
| in_valid | input | 1 | Offer one trace (in_pt, in_sample) |
| in_pt | input | 8 | Known plaintext byte of the trace |
| in_sample | input | SW | Measured leakage sample, unsigned |
| start | input | 1 | Request a ranking scan over all guesses |
| busy | output | 1 | Absorbing a trace or scanning |
| result_valid | output | 1 | best_key holds a finished ranking |
| best_key | output | 8 | Winning key-byte guess |
| trace_count | output | CW | Number of traces absorbed since clear |

## Verification
The bench targets a correlation of -1, which a design ranking by signed value would miss by returning some other guess. It also covers a constant sample column, where every score is zero and a design with a non-strict compare or a bad initial best would return a nonzero key. Two-trace sets make many guesses tie at magnitude one, so a design that breaks ties toward later guesses disagrees with the lowest index. Traces and starts injected mid-busy catch a design that double-counts. A saturation run catches a counter that wraps to zero and silently restarts the sums.

// File: rtl/cpa_rank_engine.sv
module cpa_rank_engine #(
  parameter int SW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  input  logic [7:0]    in_pt,
  input  logic [SW-1:0] in_sample,
  input  logic          start,
  output logic          busy,
  output logic          result_valid,
  output logic [7:0]    best_key,
  output logic [CW-1:0] trace_count
);
  localparam int NK  = 256;
  localparam int HSW = CW + 3;
  localparam int HQW = CW + 6;
  localparam int HTW = SW + CW + 3;
  localparam int TSW = SW + CW;
  localparam int TQW = 2 * SW + CW;
  localparam int NW  = 2 * CW + SW + 4;
  localparam int N2W = 2 * NW;
  localparam int VW  = 2 * CW + 6;
  localparam int PW  = N2W + VW;
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [1:0] {IDLE, ACC, SCAN} state_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = xtime(x);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] p, r;
    p = x;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  state_t          state;
  logic [7:0]      k;
  logic [7:0]      pt_r;
  logic [SW-1:0]   smp_r;
  logic [CW-1:0]   cnt;
  logic [TSW-1:0]  st;
  logic [TQW-1:0]  stq;
  logic [N2W-1:0]  bn2;
  logic [VW-1:0]   bv;
  logic [7:0]      bk;
  logic            rv;

  logic [HSW-1:0]  sh_a  [NK];
  logic [HQW-1:0]  shq_a [NK];
  logic [HTW-1:0]  sht_a [NK];

  logic [3:0]             hw;
  logic [NW-1:0]          pa, pb;
  logic signed [NW-1:0]   num;
  logic signed [N2W-1:0]  n2s;
  logic [N2W-1:0]         n2u;
  logic [VW-1:0]          vh;
  logic [PW-1:0]          lhs, rhs;
  logic                   win;
  logic                   take_trace, take_scan;

  assign hw  = 4'($countones(sbox(pt_r ^ k)));
  assign pa  = NW'(cnt) * NW'(sht_a[k]);
  assign pb  = NW'(sh_a[k]) * NW'(st);
  assign num = $signed(pa - pb);
  assign n2s = N2W'(num) * N2W'(num);
  assign n2u = n2s;
  assign vh  = VW'(cnt) * VW'(shq_a[k]) - VW'(sh_a[k]) * VW'(sh_a[k]);
  assign lhs = PW'(n2u) * PW'(bv);
  assign rhs = PW'(bn2) * PW'(vh);
  assign win = (vh != '0) && (lhs > rhs);

  assign take_trace = (state == IDLE) && in_valid && (cnt != CMAX);
  assign take_scan  = (state == IDLE) && !take_trace && start && (cnt >= CW'(2));

  assign busy         = (state != IDLE);
  assign result_valid = rv;
  assign best_key     = bk;
  assign trace_count  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      k     <= '0;
      pt_r  <= '0;
      smp_r <= '0;
      cnt   <= '0;
      st    <= '0;
      stq   <= '0;
      bn2   <= '0;
      bv    <= VW'(1);
      bk    <= '0;
      rv    <= 1'b0;
    end else if (clear) begin
      state <= IDLE;
      k     <= '0;
      cnt   <= '0;
      st    <= '0;
      stq   <= '0;
      rv    <= 1'b0;
    end else begin
      case (state)
        IDLE: begin
          if (take_trace) begin
            pt_r  <= in_pt;
            smp_r <= in_sample;
            cnt   <= cnt + CW'(1);
            st    <= st + TSW'(in_sample);
            stq   <= stq + TQW'(in_sample) * TQW'(in_sample);
            rv    <= 1'b0;
            k     <= '0;
            state <= ACC;
          end else if (take_scan) begin
            bn2   <= '0;
            bv    <= VW'(1);
            bk    <= '0;
            rv    <= 1'b0;
            k     <= '0;
            state <= SCAN;
          end
        end
        ACC: begin
          k <= k + 8'd1;
          if (k == 8'hff) state <= IDLE;
        end
        SCAN: begin
          if (win) begin
            bn2 <= n2u;
            bv  <= vh;
            bk  <= k;
          end
          k <= k + 8'd1;
          if (k == 8'hff) begin
            state <= IDLE;
            rv    <= 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !clear && state == ACC) begin
      if (cnt == CW'(1)) begin
        sh_a[k]  <= HSW'(hw);
        shq_a[k] <= HQW'(hw) * HQW'(hw);
        sht_a[k] <= HTW'(hw) * HTW'(smp_r);
      end else begin
        sh_a[k]  <= sh_a[k] + HSW'(hw);
        shq_a[k] <= shq_a[k] + HQW'(hw) * HQW'(hw);
        sht_a[k] <= sht_a[k] + HTW'(hw) * HTW'(smp_r);
      end
    end
  end
endmodule

// File: rtl/cpa_rank_engine_chk.sv
module cpa_rank_engine_chk #(
  parameter int SW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          in_valid,
  input logic          start,
  input logic          busy,
  input logic          result_valid,
  input logic [7:0]    best_key,
  input logic [CW-1:0] trace_count
);
  localparam logic [CW-1:0] CMAX = '1;

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && in_valid && !busy && trace_count != CMAX) |=>
      (busy && trace_count == $past(trace_count) + CW'(1)));

  p_busy_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clear) |=> $stable(trace_count));

  p_two_traces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (trace_count >= CW'(2)));

  p_result_after_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_valid) |-> $past(busy));

  p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !busy && !clear && !in_valid && !start) |=>
      (result_valid && $stable(best_key)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (trace_count == '0 && !result_valid && !busy));

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_count == CMAX && !clear) |=> (trace_count == CMAX));
endmodule

bind cpa_rank_engine cpa_rank_engine_chk #(.SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .start(start),
  .busy(busy), .result_valid(result_valid), .best_key(best_key), .trace_count(trace_count)
);

// File: tb/cpa_rank_engine_tb.sv
module cpa_rank_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_pt = '0;
  logic [7:0] in_sample = '0;
  logic       start = 1'b0;
  logic       busy, result_valid;
  logic [7:0] best_key;
  logic [7:0] trace_count;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;
  int sb  [256];
  int tpt [256];
  int tsm [256];
  int nd = 0;

  localparam int NV = 5;
  localparam logic [7:0] VKEY [NV] = '{8'h3c, 8'ha5, 8'h11, 8'h00, 8'h7e};
  localparam int VMODE [NV] = '{0, 1, 2, 3, 0};
  localparam int VNTR  [NV] = '{12, 10, 16, 6, 2};

  always #4 clk = ~clk;

  cpa_rank_engine u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_pt(in_pt),
    .in_sample(in_sample), .start(start), .busy(busy), .result_valid(result_valid),
    .best_key(best_key), .trace_count(trace_count)
  );

  function automatic int mul2(int a);
    int r;
    r = (a << 1) & 255;
    if (a & 128) r = r ^ 27;
    return r;
  endfunction

  function automatic int gfm(int a, int b);
    int r, x;
    r = 0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) r = r ^ x;
      x = mul2(x);
    end
    return r;
  endfunction

  function automatic int hwk(int p, int k);
    return $countones(8'(sb[(p ^ k) & 255]));
  endfunction

  function automatic int mk_sample(int mode, int key, int p, int d);
    int h;
    h = hwk(p, key);
    case (mode)
      0: return 10 + 20 * h;
      1: return 200 - 20 * h;
      2: return 5 * h + ((d * 53 + 7) % 32);
      default: return 77;
    endcase
  endfunction

  function automatic int model_best();
    longint sT, n2, v, num, bn2, bv, sH, sHQ, sHT, D;
    int bk, h;
    D = nd;
    sT = 0;
    for (int d = 0; d < nd; d++) sT += tsm[d];
    bn2 = 0; bv = 1; bk = 0;
    for (int k = 0; k < 256; k++) begin
      sH = 0; sHQ = 0; sHT = 0;
      for (int d = 0; d < nd; d++) begin
        h = hwk(tpt[d], k);
        sH += h; sHQ += h * h; sHT += h * tsm[d];
      end
      num = D * sHT - sH * sT;
      v   = D * sHQ - sH * sH;
      n2  = num * num;
      if (v != 0 && n2 * bv > bn2 * v) begin
        bn2 = n2; bv = v; bk = k;
      end
    end
    return bk;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    nd = 0;
  endtask

  task automatic push_trace(input int p, input int s, input bit junk, output int nb);
    @(negedge clk);
    in_valid = 1'b1; in_pt = 8'(p); in_sample = 8'(s);
    @(negedge clk);
    in_valid = 1'b0;
    nb = 0;
    while (busy) begin
      nb++;
      if (junk && nb == 3) begin
        in_valid = 1'b1; in_pt = 8'hff; in_sample = 8'hff; start = 1'b1;
      end else begin
        in_valid = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; start = 1'b0;
    tpt[nd] = p; tsm[nd] = s; nd++;
  endtask

  task automatic run_scan(output int nb);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    nb = 0;
    while (busy) begin
      nb++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int nb, exp_k, p, s;
    for (int x = 0; x < 256; x++) begin
      int inv, b;
      inv = 0;
      for (int y = 1; y < 256; y++) if (gfm(x, y) == 1) inv = y;
      b = inv;
      for (int r = 1; r < 5; r++) b = b ^ (((inv << r) | (inv >> (8 - r))) & 255);
      sb[x] = b ^ 99;
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(!result_valid, "R1 result_valid", result_valid, 0);
    chk(trace_count == 0, "R1 trace_count", trace_count, 0);
    chk(best_key == 0, "R1 best_key", best_key, 0);

    // R7: start with zero and with one trace is ignored
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!busy && !result_valid, "R7 start with 0 traces", busy, 0);
    push_trace(8'h21, 40, 0, nb);
    chk(nb == 256, "R2 busy cycles per trace", nb, 256);
    chk(trace_count == 1, "R2 count after one trace", trace_count, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!busy && !result_valid, "R7 start with 1 trace", busy, 0);

    // table of scenarios: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      do_clear();
      chk(trace_count == 0 && !result_valid, "R9 clear state", trace_count, 0);
      for (int d = 0; d < VNTR[v]; d++) begin
        p = (d * 97 + 13 + v * 29) & 255;
        s = mk_sample(VMODE[v], VKEY[v], p, d);
        push_trace(p, s, 0, nb);
        chk(nb == 256, "R2 busy cycles", nb, 256);
      end
      chk(trace_count == 8'(VNTR[v]), "R2 trace_count", trace_count, VNTR[v]);
      run_scan(nb);
      chk(nb == 256, "R8 scan cycles", nb, 256);
      chk(result_valid, "R8 result_valid", result_valid, 1);
      exp_k = model_best();
      chk(best_key == 8'(exp_k), "R4 R5 R6 best_key vs model", best_key, exp_k);
      if (VMODE[v] == 1) chk(best_key == VKEY[v], "R5 negative correlation key", best_key, VKEY[v]);
      if (VMODE[v] == 0 && VNTR[v] > 2) chk(best_key == VKEY[v], "R5 planted key", best_key, VKEY[v]);
      if (VMODE[v] == 3) chk(best_key == 0, "R6 zero scores give key 0", best_key, 0);
    end

    // R8 hold, then a new trace drops result_valid
    repeat (5) @(negedge clk);
    chk(result_valid && best_key == 8'h00, "R8 result held", best_key, 0);
    do_clear();
    for (int d = 0; d < 6; d++) begin
      p = (d * 61 + 5) & 255;
      s = mk_sample(0, 8'h5a, p, d);
      push_trace(p, s, d == 2, nb);
      chk(trace_count == 8'(d + 1), "R3 busy input ignored count", trace_count, d + 1);
    end
    run_scan(nb);
    chk(best_key == 8'h5a, "R3 result unaffected by ignored inputs", best_key, 8'h5a);
    repeat (4) @(negedge clk);
    chk(result_valid && best_key == 8'h5a, "R8 held after idle", best_key, 8'h5a);
    push_trace(8'h44, 90, 0, nb);
    chk(!result_valid, "R8 cleared by new trace", result_valid, 0);

    // R9 clear while busy
    @(negedge clk); in_valid = 1'b1; in_pt = 8'h10; in_sample = 8'd50;
    @(negedge clk); in_valid = 1'b0;
    repeat (10) @(negedge clk);
    clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk(!busy && trace_count == 0 && !result_valid, "R9 clear aborts", busy, 0);
    nd = 0;

    // R10 saturation
    for (int d = 0; d < 255; d++) push_trace(d, d & 63, 0, nb);
    chk(trace_count == 8'd255, "R10 count at max", trace_count, 255);
    @(negedge clk); in_valid = 1'b1; in_pt = 8'h01; in_sample = 8'd3;
    @(negedge clk); in_valid = 1'b0;
    chk(!busy && trace_count == 8'd255, "R10 trace ignored at max", trace_count, 255);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule